// File: doc/BRIEF.md
# Card Host Interrupt Status and Mask Registers

This block collects event pulses from a card host's command, data and FIFO logic into a raw status word with one fixed bit per event. Software reads that word, clears the bits it has handled by writing ones, and selects which events may raise an interrupt through a mask register. A read-only view returns the raw word gated by the mask.

From the masked bits, the block also produces two summary flags. One tells whether any error event is pending. The other tells whether any completion event is pending. A single registered interrupt line follows the masked status, gated by a global enable bit in a control register.

Access is through a plain 32-bit word-addressed port. Writes take effect on the clock edge. Reads are combinational from the current register state.

The register offsets (word index on `reg_addr`) are:
- 0: control. Bit 4 is the interrupt enable; every other bit reads zero.
- 1: mask.
- 2: masked status, read-only.
- 3: raw status, where writing a one clears that bit.

The raw bit positions are:
- Completions: command done = 2, data over = 3, voltage switch done = 10, auto-command done = 14.
- Data requests: transmit = 4, receive = 5.
- Errors: response error = 1, response CRC = 6, data CRC = 7, response timeout = 8, data timeout = 9, FIFO under/overrun = 11, hardware locked = 12, start-bit = 13, end-bit = 15.
- Other events: SDIO interrupt = 16, card insert = 30, card remove = 31.

Top module: `card_irq_regs`

## Requirements
- R1: After reset, the control, mask, masked-status and raw-status registers all read zero, and `irq`, `err_pending` and `done_pending` are low.
- R2: A one on `evt_pulse` at an implemented bit position (1 to 16, 30, 31) sets that raw bit on the next clock edge. The bit then stays set until software clears it.
- R3: A write to offset 3 clears each raw bit whose written bit is one. Raw bits where the written bit is zero keep their value.
- R4: When an event pulse and a clearing write hit the same raw bit in the same cycle, the bit ends up set.
- R5: Offset 2 reads raw AND mask. A write to offset 2 changes neither register.
- R6: Bit 0, bits 17 to 29 and every control bit other than 4 read zero. Writes and event pulses on those positions have no effect.
- R7: `err_pending` is high exactly when a masked status bit in the error group {1,6,7,8,9,11,12,13,15} is set. It follows the register state in the same cycle.
- R8: `done_pending` is high exactly when a masked status bit in the completion group {2,3,10,14} is set. It follows the register state in the same cycle.
- R9: `irq` is registered. It is high in the cycle after the masked status is nonzero while control bit 4 is one. It is low in the cycle after either condition is gone.
- R10: Control bit 4 is written and read at offset 0. With bit 4 at zero, `irq` stays low whatever the masked status holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Word offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| evt_pulse | input | 32 | One-cycle event pulses, one per raw status bit |
| err_pending | output | 1 | Some masked error-group bit is set |
| done_pending | output | 1 | Some masked completion-group bit is set |
| irq | output | 1 | Registered interrupt line |

## Verification
An event pulse or a write presented before a clock edge is visible in `reg_rdata`, `err_pending` and `done_pending` after that single edge. `irq` needs a second edge, because it samples the updated masked status.

The bench drives stimulus on the falling edge and lets exactly one rising edge pass before it reads registers or summaries. It then waits one further edge before checking `irq`, and it also checks `irq` one edge earlier to confirm the line has not moved too soon. The set-versus-clear collision is driven in a single cycle, so both operations land on the same edge.

// File: rtl/card_irq_pkg.sv
package card_irq_pkg;
   localparam int unsigned REG_W   = 32;
   localparam int unsigned OFS_W   = 2;

   localparam logic [OFS_W-1:0] OFS_CTRL   = 2'd0;
   localparam logic [OFS_W-1:0] OFS_MASK   = 2'd1;
   localparam logic [OFS_W-1:0] OFS_MSTAT  = 2'd2;
   localparam logic [OFS_W-1:0] OFS_RAW    = 2'd3;

   // bits 1..16, 30, 31 are backed by storage
   localparam logic [REG_W-1:0] IMPL_BITS  = 32'hC001_FFFE;
   // response error, CRC errors, timeouts, FIFO run, locked, start/end bit
   localparam logic [REG_W-1:0] ERR_BITS   = 32'h0000_BBC2;
   // command done, data over, voltage switch done, auto-command done
   localparam logic [REG_W-1:0] DONE_BITS  = 32'h0000_440C;

   localparam int unsigned IRQ_EN_POS = 4;
endpackage

// File: rtl/card_irq_raw.sv
module card_irq_raw
   import card_irq_pkg::*;
#(
   parameter int unsigned            W    = REG_W,
   parameter logic [W-1:0]           IMPL = IMPL_BITS
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_vec,
   input  logic [W-1:0] clr_vec,
   output logic [W-1:0] raw_q
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      if (IMPL[b]) begin : g_live
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n)            bit_q <= 1'b0;
            else if (set_vec[b])   bit_q <= 1'b1;   // set has priority
            else if (clr_vec[b])   bit_q <= 1'b0;
         end
         assign raw_q[b] = bit_q;
      end else begin : g_tied
         assign raw_q[b] = 1'b0;
      end
   end
endmodule

// File: rtl/card_irq_cfg.sv
module card_irq_cfg
   import card_irq_pkg::*;
#(
   parameter int unsigned  W      = REG_W,
   parameter logic [W-1:0] IMPL   = IMPL_BITS,
   parameter int unsigned  EN_POS = IRQ_EN_POS
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         mask_we,
   input  logic         ctrl_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] mask_q,
   output logic         irq_en_q
);
   logic [W-1:0] mask_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_r   <= '0;
         irq_en_q <= 1'b0;
      end else begin
         if (mask_we) mask_r   <= wdata & IMPL;
         if (ctrl_we) irq_en_q <= wdata[EN_POS];
      end
   end

   assign mask_q = mask_r;
endmodule

// File: rtl/card_irq_sum.sv
module card_irq_sum
   import card_irq_pkg::*;
#(
   parameter int unsigned  W       = REG_W,
   parameter logic [W-1:0] ERR     = ERR_BITS,
   parameter logic [W-1:0] DONE    = DONE_BITS,
   parameter bit           IRQ_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw_q,
   input  logic [W-1:0] mask_q,
   input  logic         irq_en,
   output logic [W-1:0] masked,
   output logic         err_any,
   output logic         done_any,
   output logic         irq
);
   logic irq_next;

   assign masked   = raw_q & mask_q;
   assign err_any  = |(masked & ERR);
   assign done_any = |(masked & DONE);
   assign irq_next = irq_en && (|masked);

   if (IRQ_REG) begin : g_flop
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_next;
      end
      assign irq = irq_q;
   end else begin : g_comb
      assign irq = irq_next;
   end
endmodule

// File: rtl/card_irq_regs.sv
module card_irq_regs
   import card_irq_pkg::*;
#(
   parameter int unsigned      W       = REG_W,
   parameter int unsigned      AW      = OFS_W,
   parameter logic [W-1:0]     IMPL    = IMPL_BITS,
   parameter logic [W-1:0]     ERR     = ERR_BITS,
   parameter logic [W-1:0]     DONE    = DONE_BITS,
   parameter int unsigned      EN_POS  = IRQ_EN_POS,
   parameter bit               IRQ_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [AW-1:0] reg_addr,
   input  logic [W-1:0]  reg_wdata,
   output logic [W-1:0]  reg_rdata,
   input  logic [W-1:0]  evt_pulse,
   output logic          err_pending,
   output logic          done_pending,
   output logic          irq
);
   localparam logic [W-1:0] CTRL_RD = W'(1) << EN_POS;

   if (W < 32)           begin : g_chk_w   $error("W must be at least 32");     end
   if (AW < 2)           begin : g_chk_aw  $error("AW must cover 4 offsets");   end
   if (EN_POS >= W)      begin : g_chk_en  $error("EN_POS out of range");       end
   if ((ERR & ~IMPL) != '0)  begin : g_chk_e $error("ERR outside IMPL");     end
   if ((DONE & ~IMPL) != '0) begin : g_chk_d $error("DONE outside IMPL");    end

   logic [W-1:0] raw_q, mask_q, masked, clr_vec;
   logic         irq_en_q, err_any, done_any;

   assign clr_vec = (reg_we && reg_addr == AW'(OFS_RAW)) ? reg_wdata : '0;

   card_irq_raw #(.W(W), .IMPL(IMPL)) u_raw (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (evt_pulse & IMPL),
      .clr_vec (clr_vec),
      .raw_q   (raw_q)
   );

   card_irq_cfg #(.W(W), .IMPL(IMPL), .EN_POS(EN_POS)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask_we  (reg_we && reg_addr == AW'(OFS_MASK)),
      .ctrl_we  (reg_we && reg_addr == AW'(OFS_CTRL)),
      .wdata    (reg_wdata),
      .mask_q   (mask_q),
      .irq_en_q (irq_en_q)
   );

   card_irq_sum #(.W(W), .ERR(ERR), .DONE(DONE), .IRQ_REG(IRQ_REG)) u_sum (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_q    (raw_q),
      .mask_q   (mask_q),
      .irq_en   (irq_en_q),
      .masked   (masked),
      .err_any  (err_any),
      .done_any (done_any),
      .irq      (irq)
   );

   always_comb begin
      reg_rdata = '0;
      if      (reg_addr == AW'(OFS_CTRL))  reg_rdata = irq_en_q ? CTRL_RD : '0;
      else if (reg_addr == AW'(OFS_MASK))  reg_rdata = mask_q;
      else if (reg_addr == AW'(OFS_MSTAT)) reg_rdata = masked;
      else if (reg_addr == AW'(OFS_RAW))   reg_rdata = raw_q;
   end

   assign err_pending  = err_any;
   assign done_pending = done_any;
endmodule

// File: rtl/card_irq_regs_checker.sv
module card_irq_regs_checker
   import card_irq_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        reg_we,
   input logic [1:0]  reg_addr,
   input logic [31:0] reg_wdata,
   input logic [31:0] evt_pulse,
   input logic [31:0] raw_q,
   input logic [31:0] mask_q,
   input logic        irq_en_q,
   input logic        err_pending,
   input logic        done_pending,
   input logic        irq
);
   assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_pulse & IMPL_BITS)) |=>
         ((raw_q & $past(evt_pulse & IMPL_BITS)) == $past(evt_pulse & IMPL_BITS)));

   assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == OFS_RAW && evt_pulse == '0) |=>
         (raw_q == ($past(raw_q) & ~$past(reg_wdata))));

   assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == OFS_RAW && |(evt_pulse & reg_wdata & IMPL_BITS)) |=>
         ((raw_q & $past(evt_pulse & reg_wdata & IMPL_BITS)) != '0));

   assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((raw_q & ~IMPL_BITS) == '0) && ((mask_q & ~IMPL_BITS) == '0));

   assert_err_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_pending == (|(raw_q & mask_q & ERR_BITS)));

   assert_done_sum_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_pending == (|(raw_q & mask_q & DONE_BITS)));

   assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en_q && |(raw_q & mask_q)) |=> irq);

   assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en_q || (raw_q & mask_q) == '0) |=> !irq);
endmodule

bind card_irq_regs card_irq_regs_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_we       (reg_we),
   .reg_addr     (reg_addr),
   .reg_wdata    (reg_wdata),
   .evt_pulse    (evt_pulse),
   .raw_q        (raw_q),
   .mask_q       (mask_q),
   .irq_en_q     (irq_en_q),
   .err_pending  (err_pending),
   .done_pending (done_pending),
   .irq          (irq)
);

// File: tb/card_irq_regs_bench.sv
`timescale 1ns/1ps
module card_irq_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] evt_pulse = '0;
   logic        err_pending, done_pending, irq;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   card_irq_regs u_card_irq_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
      .err_pending(err_pending), .done_pending(done_pending), .irq(irq)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   // one write, landing on the next rising edge; returns at the falling edge after
   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic pulse(input logic [31:0] bits);
      evt_pulse = bits;
      @(negedge clk);
      evt_pulse = '0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), d);
         check("R1 reg after reset", d, 32'h0);
      end
      check("R1 irq", {31'b0, irq}, 0);
      check("R1 err_pending", {31'b0, err_pending}, 0);
      check("R1 done_pending", {31'b0, done_pending}, 0);
   endtask

   task automatic t_set_hold;
      logic [31:0] d;
      pulse(32'h0000_0004);
      rd(2'd3, d);
      check("R2 raw set", d, 32'h4);
      repeat (3) @(negedge clk);
      rd(2'd3, d);
      check("R2 raw held", d, 32'h4);
      wr(2'd3, 32'hFFFF_FFFF);
   endtask

   task automatic t_reserved;
      logic [31:0] d;
      pulse(32'hFFFF_FFFF);
      rd(2'd3, d);
      check("R6 raw reserved", d, 32'hC001_FFFE);
      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd1, d);
      check("R6 mask reserved", d, 32'hC001_FFFE);
      wr(2'd0, 32'hFFFF_FFEF);
      rd(2'd0, d);
      check("R6 ctrl reserved", d, 32'h0);
      check("R10 irq off while disabled", {31'b0, irq}, 0);
      wr(2'd1, 32'h0);
      wr(2'd3, 32'hFFFF_FFFF);
   endtask

   task automatic t_w1c;
      logic [31:0] d;
      pulse(32'h4000_030C);
      wr(2'd3, 32'h0000_0204);
      rd(2'd3, d);
      check("R3 partial clear", d, 32'h4000_0108);
      wr(2'd3, 32'h0);
      rd(2'd3, d);
      check("R3 zero write keeps", d, 32'h4000_0108);
      wr(2'd3, 32'hFFFF_FFFF);
      rd(2'd3, d);
      check("R3 full clear", d, 32'h0);
   endtask

   task automatic t_collision;
      logic [31:0] d;
      pulse(32'h0000_0004);
      evt_pulse = 32'h0000_0008;
      wr(2'd3, 32'h0000_000C);
      evt_pulse = '0;
      rd(2'd3, d);
      check("R4 set wins, other cleared", d, 32'h8);
      wr(2'd3, 32'hFFFF_FFFF);
   endtask

   task automatic t_masked;
      logic [31:0] d;
      wr(2'd1, 32'h0000_0104);
      pulse(32'h0000_010C);
      rd(2'd2, d);
      check("R5 masked view", d, 32'h0000_0104);
      wr(2'd2, 32'hFFFF_FFFF);
      rd(2'd1, d);
      check("R5 masked write leaves mask", d, 32'h0000_0104);
      rd(2'd3, d);
      check("R5 masked write leaves raw", d, 32'h0000_010C);
      wr(2'd3, 32'hFFFF_FFFF);
      wr(2'd1, 32'h0);
   endtask

   task automatic t_summary;
      wr(2'd1, 32'hFFFF_FFFF);
      pulse(32'h0000_0010);
      check("R7 no error from tx req", {31'b0, err_pending}, 0);
      check("R8 no done from tx req", {31'b0, done_pending}, 0);
      pulse(32'h0000_8000);
      check("R7 end-bit error", {31'b0, err_pending}, 1);
      pulse(32'h0000_4000);
      check("R8 auto-cmd done", {31'b0, done_pending}, 1);
      wr(2'd1, 32'h0000_0010);
      check("R7 masked off", {31'b0, err_pending}, 0);
      check("R8 masked off", {31'b0, done_pending}, 0);
      wr(2'd3, 32'hFFFF_FFFF);
      wr(2'd1, 32'h0);
   endtask

   task automatic t_irq;
      logic [31:0] d;
      wr(2'd0, 32'h0000_0010);
      rd(2'd0, d);
      check("R10 enable readback", d, 32'h10);
      wr(2'd1, 32'h0000_0004);
      pulse(32'h0000_0004);
      check("R9 irq not yet", {31'b0, irq}, 0);
      @(negedge clk);
      check("R9 irq asserted", {31'b0, irq}, 1);
      wr(2'd0, 32'h0);
      check("R10 irq one edge after disable", {31'b0, irq}, 1);
      @(negedge clk);
      check("R10 irq dropped on disable", {31'b0, irq}, 0);
      wr(2'd0, 32'h0000_0010);
      @(negedge clk);
      check("R9 irq back", {31'b0, irq}, 1);
      wr(2'd3, 32'h0000_0004);
      @(negedge clk);
      check("R9 irq low after clear", {31'b0, irq}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set_hold();
      t_reserved();
      t_w1c();
      t_collision();
      t_masked();
      t_summary();
      t_irq();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule